// File: doc/BRIEF.md
# Bus-Addressed Channel Select Latch

This block is the digital control core of an eight-way analog selector that sits on a microprocessor bus. A host places a 3-bit channel code on the address pins and pulls the active-low write strobe low. While the strobe stays low in input mode, the switch enables follow the code on the pins. When the strobe returns high, the code from the last core clock edge inside the strobe is held, and the switches keep that route.

The same pins can carry the stored code back to the host, so the host can poll the route that is selected, for example after its own power cycle. A third pin state leaves the pins undriven, so many selectors can share one data bus. The pins are modelled as separate in, out and output-enable signals.

A pair-mode input turns the eight single-ended channels into four differential pairs. In that mode the top address bit is ignored. An active-low master reset acts at once without a clock. It wipes the stored code, opens every switch, stops any pin drive, and wins over every other input.

Top module: `swmux_ctrl`

## Requirements
- R1: In input mode (dir_out=0, wr_n=0, en=1, rst_n=1) the switch outputs follow addr_i in the same cycle, with no clock edge needed.
- R2: The stored code is loaded only at a rising clk edge in input mode. At every other time it holds, whatever addr_i does, including while dir_out=1 with wr_n=0.
- R3: While rst_n=0, sw_en is all zero and addr_oe is 0 immediately, without waiting for clk, whatever the other inputs are. No code is loaded during reset.
- R4: After rst_n rises, sw_en stays all zero and the read-back code is 0 until a load takes place.
- R5: In single-ended mode (pair_mode=0), code k closes only sw_en bit k. Bits 0..3 are bank A switches 1..4 and bits 4..7 are bank B switches 1..4, so at most one bit is ever set.
- R6: In pair mode (pair_mode=1), code k closes bits k[1:0] and k[1:0]+4 together, and address bit 2 has no effect.
- R7: While en=0, sw_en is all zero and the stored code keeps its value.
- R8: With dir_out=1, wr_n=1, en=1 and rst_n=1, addr_oe is 1 and addr_o carries the stored code.
- R9: addr_oe is 0 whenever dir_out=0, whatever en is. It is also 0 when dir_out=1 with wr_n=0 or en=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the code while the strobe is low |
| rst_n | input | 1 | Asynchronous active-low master reset |
| wr_n | input | 1 | Active-low write strobe |
| en | input | 1 | Device enable; 0 opens all switches |
| dir_out | input | 1 | Pin direction: 0 = listen, 1 = read-back |
| pair_mode | input | 1 | 1 = four differential pairs, 0 = eight single channels |
| addr_i | input | 3 | Code sensed on the address pins |
| addr_o | output | 3 | Code driven onto the address pins |
| addr_oe | output | 1 | Drive enable for the address pins |
| sw_en | output | 8 | Switch closures; [3:0] bank A, [7:4] bank B |

## Verification
The load assertion assumes that addr_i is steady across the clk edge that ends a strobe, so the held code equals the code seen while the strobe was low. The bench therefore changes addr_i and the strobe only on falling clk edges and holds every write for a full clock period. The clocked properties also assume that reset is released away from a rising edge. The bench drops and raises rst_n in mid-period, and checks the immediate effect of reset at the ports rather than through properties.

// File: rtl/swmux_pkg.sv
package swmux_pkg;

  // Bus-side state of the control pins, decided from the four controls.
  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,  // pins undriven, no load
    BUS_TAKE  = 2'd1,  // pins listened to, code loaded
    BUS_SHOW  = 2'd2,  // stored code driven back
    BUS_CLEAR = 2'd3   // master reset in force
  } bus_mode_e;

  // Reset first, then the two active states; anything else idles.
  function automatic bus_mode_e classify(input logic rst_n, input logic dir_out,
                                         input logic wr_n, input logic en);
    if (!rst_n)                      return BUS_CLEAR;
    else if (!dir_out && !wr_n && en) return BUS_TAKE;
    else if (dir_out && wr_n && en)   return BUS_SHOW;
    else                              return BUS_IDLE;
  endfunction

endpackage

// File: rtl/swmux_addr_store.sv
module swmux_addr_store #(
  parameter int unsigned AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q,
  output logic          armed
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q     <= '0;
      armed <= 1'b0;
    end else if (load) begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  // R2: a load edge captures the pins
  a_r2_capture : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d)));

  // R2: no load, no change
  a_r2_hold : assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

  // R4: once armed, only reset disarms
  a_r4_armed_sticky : assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);

endmodule

// File: rtl/swmux_route_decode.sv
module swmux_route_decode #(
  parameter int unsigned AW = 3
) (
  input  logic               active,
  input  logic               pair_mode,
  input  logic [AW-1:0]      sel,
  output logic [(1<<AW)-1:0] sw_en
);

  localparam int unsigned NCH = 1 << AW;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam logic [AW-1:0] K = AW'(k);
    logic hit_single;
    logic hit_pair;
    assign hit_single = (sel == K);
    assign hit_pair   = (sel[AW-2:0] == K[AW-2:0]);
    assign sw_en[k]   = active & (pair_mode ? hit_pair : hit_single);
  end

endmodule

// File: rtl/swmux_bus_port.sv
module swmux_bus_port #(
  parameter int unsigned AW = 3
) (
  input  swmux_pkg::bus_mode_e mode,
  input  logic [AW-1:0]        stored,
  output logic [AW-1:0]        addr_o,
  output logic                 addr_oe
);

  always_comb begin
    addr_oe = (mode == swmux_pkg::BUS_SHOW);
    addr_o  = addr_oe ? stored : '0;
  end

endmodule

// File: rtl/swmux_ctrl.sv
module swmux_ctrl #(
  parameter int unsigned AW = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_n,
  input  logic               en,
  input  logic               dir_out,
  input  logic               pair_mode,
  input  logic [AW-1:0]      addr_i,
  output logic [AW-1:0]      addr_o,
  output logic               addr_oe,
  output logic [(1<<AW)-1:0] sw_en
);

  localparam int unsigned NCH = 1 << AW;

  swmux_pkg::bus_mode_e mode;
  logic                 load;
  logic [AW-1:0]        stored;
  logic                 armed;
  logic [AW-1:0]        sel;
  logic                 active;

  always_comb begin
    mode   = swmux_pkg::classify(rst_n, dir_out, wr_n, en);
    load   = (mode == swmux_pkg::BUS_TAKE);
    sel    = load ? addr_i : stored;
    active = (mode != swmux_pkg::BUS_CLEAR) && en && (load || armed);
  end

  swmux_addr_store #(.AW(AW)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .d     (addr_i),
    .q     (stored),
    .armed (armed)
  );

  swmux_route_decode #(.AW(AW)) u_decode (
    .active    (active),
    .pair_mode (pair_mode),
    .sel       (sel),
    .sw_en     (sw_en)
  );

  swmux_bus_port #(.AW(AW)) u_port (
    .mode    (mode),
    .stored  (stored),
    .addr_o  (addr_o),
    .addr_oe (addr_oe)
  );

  // R5: single-ended closes one switch at most
  a_r5_single_onehot : assert property (@(posedge clk) disable iff (!rst_n)
    !pair_mode |-> $onehot0(sw_en));

  // R6: pair mode closes two switches or none
  a_r6_pair_count : assert property (@(posedge clk) disable iff (!rst_n)
    (pair_mode && (sw_en != '0)) |-> ($countones(sw_en) == 2));

  // R6: the pair is one bank-A and the matching bank-B bit
  a_r6_pair_banks : assert property (@(posedge clk) disable iff (!rst_n)
    pair_mode |-> (sw_en[NCH/2-1:0] == sw_en[NCH-1:NCH/2]));

  // R7: disabled means open
  a_r7_en_low_open : assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (sw_en == '0));

  // R4: nothing closes before the first load
  a_r4_unarmed_open : assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && wr_n) |-> (sw_en == '0));

  // R9: never drive while listening
  a_r9_no_drive_listen : assert property (@(posedge clk) disable iff (!rst_n)
    !dir_out |-> !addr_oe);

endmodule

// File: tb/swmux_ctrl_tb.sv
module swmux_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n, wr_n, en, dir_out, pair_mode;
  logic [2:0] addr_i;
  logic [2:0] addr_o;
  logic       addr_oe;
  logic [7:0] sw_en;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  swmux_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .en(en), .dir_out(dir_out),
    .pair_mode(pair_mode), .addr_i(addr_i), .addr_o(addr_o),
    .addr_oe(addr_oe), .sw_en(sw_en)
  );

  function automatic logic [7:0] want_sw(input logic [2:0] a, input logic pr);
    logic [7:0] v;
    if (pr) v = 8'h11 << a[1:0];
    else    v = 8'h01 << a;
    return v;
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic write_code(input logic [2:0] a);
    @(negedge clk);
    dir_out = 1'b0; en = 1'b1; wr_n = 1'b0; addr_i = a;
    #2 check("R1 transparent", sw_en, want_sw(a, pair_mode));
    @(negedge clk);
    wr_n = 1'b1;
    #2;
  endtask

  task automatic read_back(input logic [2:0] exp, input string req);
    @(negedge clk);
    dir_out = 1'b1; wr_n = 1'b1; en = 1'b1;
    #2 check({req, " oe"}, {7'd0, addr_oe}, 8'd1);
    check({req, " code"}, {5'd0, addr_o}, {5'd0, exp});
    @(negedge clk);
    dir_out = 1'b0;
    #2;
  endtask

  task automatic t_reset_state();
    // Reset held from time zero
    #2 check("R3 reset sw", sw_en, 8'h00);
    check("R3 reset oe", {7'd0, addr_oe}, 8'd0);
    @(negedge clk); rst_n = 1'b1;
    #2 check("R4 open after release", sw_en, 8'h00);
    read_back(3'd0, "R4 readback zero");
    check("R4 still open", sw_en, 8'h00);
  endtask

  task automatic t_single();
    pair_mode = 1'b0;
    for (int a = 0; a < 8; a++) begin
      write_code(3'(a));
      check("R5 held route", sw_en, want_sw(3'(a), 1'b0));
      read_back(3'(a), "R8 readback");
    end
  endtask

  task automatic t_hold();
    write_code(3'd5);
    addr_i = 3'd2;
    @(negedge clk); #2 check("R2 pins ignored", sw_en, want_sw(3'd5, 1'b0));
    // Strobe low while in read-back direction: no load
    dir_out = 1'b1; wr_n = 1'b0; addr_i = 3'd3;
    @(negedge clk);
    #2 check("R9 no drive, strobe low", {7'd0, addr_oe}, 8'd0);
    wr_n = 1'b1; dir_out = 1'b0;
    read_back(3'd5, "R2 no load in read dir");
  endtask

  task automatic t_pair();
    pair_mode = 1'b1;
    write_code(3'd6);
    check("R6 pair 6", sw_en, 8'h44);
    write_code(3'd2);
    check("R6 pair 2 same as 6", sw_en, 8'h44);
    write_code(3'd5);
    check("R6 pair 5", sw_en, 8'h22);
    read_back(3'd5, "R8 readback pair");
    pair_mode = 1'b0;
    #2 check("R5 back to single", sw_en, 8'h20);
  endtask

  task automatic t_enable();
    write_code(3'd3);
    @(negedge clk); en = 1'b0;
    #2 check("R7 en low open", sw_en, 8'h00);
    wr_n = 1'b0; addr_i = 3'd6;
    @(negedge clk);
    #2 check("R7 en low strobe open", sw_en, 8'h00);
    wr_n = 1'b1;
    read_back(3'd3, "R7 code kept");
    #2 check("R7 route back", sw_en, 8'h08);
  endtask

  task automatic t_float();
    @(negedge clk);
    dir_out = 1'b0; wr_n = 1'b1; en = 1'b0;
    #2 check("R9 float en0", {7'd0, addr_oe}, 8'd0);
    en = 1'b1;
    #2 check("R9 float en1", {7'd0, addr_oe}, 8'd0);
    dir_out = 1'b1; en = 1'b0;
    #2 check("R9 read dir en0", {7'd0, addr_oe}, 8'd0);
    en = 1'b1;
    #2 check("R8 drive on", {7'd0, addr_oe}, 8'd1);
    dir_out = 1'b0;
    #2;
  endtask

  task automatic t_async_reset();
    write_code(3'd7);
    @(negedge clk);
    dir_out = 1'b1; en = 1'b1; wr_n = 1'b1;
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1 check("R3 async sw", sw_en, 8'h00);
    check("R3 async oe", {7'd0, addr_oe}, 8'd0);
    // Input-mode stimulus during reset must not load
    dir_out = 1'b0; wr_n = 1'b0; addr_i = 3'd4;
    #1 check("R3 overrides input", sw_en, 8'h00);
    @(negedge clk); @(negedge clk);
    wr_n = 1'b1; rst_n = 1'b1;
    #2 check("R4 open after reset", sw_en, 8'h00);
    read_back(3'd0, "R4 cleared code");
    write_code(3'd4);
    check("R4 route after new load", sw_en, 8'h10);
  endtask

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; en = 1'b1; dir_out = 1'b1;
    pair_mode = 1'b0; addr_i = 3'd7;
    t_reset_state();
    t_single();
    t_hold();
    t_pair();
    t_enable();
    t_float();
    t_async_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, got hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule